// File: doc/BRIEF.md
# Indirect-Paged Host I/O Port Bridge

This block sits between a 16-bit host I/O bus and a 4 KB internal space of registers and buffers. The host sees only eight 16-bit ports in a 16-byte window. The window starts at a relocatable base. Every internal location is reached indirectly: the host loads a page pointer, then reads or writes a page data port, and the pointer steps forward by one word after each such access.

Other ports have fixed roles. Two data ports stream transmit frame data into the transmit buffer and stream receive frames out. A receive frame comes out as its status word, then its length word, then its data words. Further ports take the transmit command and the transmit length, and one port reads the interrupt status word.

A small set of sideband registers sits in the same internal space. They hold the window base, a buffer configuration word and a buffer event word. The event word carries a transmit-space-ready flag, and that flag can drive an interrupt line.

Top module: `indirect_io_bridge`

## Requirements
- R1: After reset the window base is 0300h. An access is claimed (`io_hit` high, combinationally) only at an even byte address whose upper twelve bits equal those of the base. A read that is not claimed returns 0000h.
- R2: A page data write while the pointer holds 0020h loads the base with the written value, its low four bits forced to zero. The new base claims accesses from the next cycle, the old one no longer does, and a page read at 0020h returns the base.
- R3: Port Ah is the page pointer. A write keeps the low twelve bits with bit 0 cleared. A read returns the pointer zero-extended to 16 bits. After reset the pointer is 0000h.
- R4: Ports Ch and Eh read or write the internal word at the pointer, and every such access adds 2 to the pointer. A 32-bit transfer writes or reads its lower word through Ch at the pointer, then its upper word through Eh at pointer+2.
- R5: Ports 4h and 6h are write-only and read as 0000h. A write to 4h stores the command at internal 0144h and restarts the transmit index at 0. A write to 6h stores the length at internal 0146h.
- R6: Port 8h returns the word at internal 0120h. Writes to port 8h are ignored and leave that word unchanged.
- R7: Writes to ports 0h and 2h store consecutive words at internal 0A00h + transmit index, and the index advances by 2 after each write. A 32-bit write therefore lands as port 0h then port 2h, lower word first.
- R8: After a one-cycle `rx_new` pulse, reads of ports 0h or 2h return, in order, the word at 0400h (status), the word at 0402h (length L in bytes), and then ceil(L/2) words from 0404h upward. After that they return 0000h and do not advance.
- R9: Bit 8 of the event word (internal 012Ch) is set on a rising edge of `tx_room` and cleared by a page write to 012Ch that has bit 8 set. `irq` is high exactly while event bit 8 and bit 8 of the config word (internal 0102h) are both set, and it becomes visible one cycle after the rising edge.
- R10: `io_rdata` is registered. It takes its new value on the clock edge that samples `io_rd` and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 16 | Host byte address |
| io_rd | input | 1 | One-cycle read strobe |
| io_wr | input | 1 | One-cycle write strobe |
| io_wdata | input | 16 | Host write data |
| io_rdata | output | 16 | Registered read data |
| io_hit | output | 1 | Address lies on an even byte inside the window |
| rx_new | input | 1 | Pulse: a new receive frame is ready; restarts the readout |
| tx_room | input | 1 | Level: transmit buffer space is available |
| irq | output | 1 | Transmit-space-ready interrupt |

## Verification
The assertions assume the host issues at most one access per cycle and never raises `io_rd` and `io_wr` together. They also assume `rx_new` is never pulsed in the same cycle as a receive-port read. The bench drives each access as a one-cycle strobe set up on the falling edge, with idle cycles between accesses. It pulses `rx_new` only while the bus is idle. Internal contents are loaded only through the page ports, so every value the checks expect comes from words the bench wrote itself.

// File: rtl/iopb_pkg.sv
package iopb_pkg;

  localparam int SPACE_AW = 12;

  typedef enum logic [2:0] {
    P_DATA0  = 3'd0,
    P_DATA1  = 3'd1,
    P_TXCMD  = 3'd2,
    P_TXLEN  = 3'd3,
    P_ISQ    = 3'd4,
    P_PTR    = 3'd5,
    P_PDATA0 = 3'd6,
    P_PDATA1 = 3'd7
  } port_e;

  localparam logic [SPACE_AW-1:0] OFF_BASE   = 12'h020;
  localparam logic [SPACE_AW-1:0] OFF_CFG    = 12'h102;
  localparam logic [SPACE_AW-1:0] OFF_ISQ    = 12'h120;
  localparam logic [SPACE_AW-1:0] OFF_EVT    = 12'h12C;
  localparam logic [SPACE_AW-1:0] OFF_TXCMD  = 12'h144;
  localparam logic [SPACE_AW-1:0] OFF_TXLEN  = 12'h146;
  localparam logic [SPACE_AW-1:0] OFF_RXST   = 12'h400;
  localparam logic [SPACE_AW-1:0] OFF_TXDATA = 12'hA00;

  localparam int EVT_BIT = 8;

endpackage

// File: rtl/iopb_decode.sv
module iopb_decode
  import iopb_pkg::*;
#(
  parameter int HOST_AW = 16
) (
  input  logic [HOST_AW-1:0] addr,
  input  logic [HOST_AW-1:0] base,
  output logic               hit,
  output port_e              port
);

  assign hit  = (addr[HOST_AW-1:4] == base[HOST_AW-1:4]) && !addr[0];
  assign port = port_e'(addr[3:1]);

endmodule

// File: rtl/iopb_ram.sv
module iopb_ram #(
  parameter int WAW = 11,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           we,
  input  logic [WAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [WAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);

  localparam int DEPTH = 1 << WAW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/iopb_stream.sv
module iopb_stream #(
  parameter int SAW = 12,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_restart,
  input  logic           rx_adv,
  input  logic [DW-1:0]  cap_word,
  input  logic           tx_restart,
  input  logic           tx_adv,
  output logic [SAW-1:0] rx_idx,
  output logic [SAW-1:0] tx_idx,
  output logic           rx_more
);

  localparam logic [SAW-1:0] HDR_BYTES = SAW'(4);
  localparam logic [SAW-1:0] LEN_IDX   = SAW'(2);
  localparam logic [SAW-1:0] STEP      = SAW'(2);

  logic [SAW-1:0] rx_idx_q, rx_idx_d;
  logic [SAW-1:0] tx_idx_q, tx_idx_d;
  logic [SAW-1:0] len_q, len_d;
  logic [SAW:0]   limit;

  // Round the byte length up to whole words, then add the two header words.
  assign limit   = ((({1'b0, len_q} + (SAW+1)'(1)) >> 1) << 1) + (SAW+1)'(HDR_BYTES);
  assign rx_more = (rx_idx_q < HDR_BYTES) || ({1'b0, rx_idx_q} < limit);

  always_comb begin
    rx_idx_d = rx_idx_q;
    len_d    = len_q;
    if (rx_restart) begin
      rx_idx_d = '0;
      len_d    = '0;
    end else if (rx_adv) begin
      rx_idx_d = rx_idx_q + STEP;
      if (rx_idx_q == LEN_IDX) begin
        len_d = SAW'(cap_word);
      end
    end
  end

  always_comb begin
    tx_idx_d = tx_idx_q;
    if (tx_restart) begin
      tx_idx_d = '0;
    end else if (tx_adv) begin
      tx_idx_d = tx_idx_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_idx_q <= '0;
      tx_idx_q <= '0;
      len_q    <= '0;
    end else begin
      rx_idx_q <= rx_idx_d;
      tx_idx_q <= tx_idx_d;
      len_q    <= len_d;
    end
  end

  assign rx_idx = rx_idx_q;
  assign tx_idx = tx_idx_q;

  AST_RX_HEADER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_adv && !rx_restart && (rx_idx_q < HDR_BYTES)) |=> (rx_idx_q == $past(rx_idx_q) + STEP)); // R8
  AST_RX_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_more && !rx_restart) |=> $stable(rx_idx_q)); // R8
  AST_TX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tx_restart |=> (tx_idx_q == '0)); // R5
  AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_adv && !tx_restart) |=> (tx_idx_q == $past(tx_idx_q) + STEP)); // R7

endmodule

// File: rtl/indirect_io_bridge.sv
module indirect_io_bridge
  import iopb_pkg::*;
#(
  parameter int                 HOST_AW    = 16,
  parameter int                 DW         = 16,
  parameter int                 SAW        = iopb_pkg::SPACE_AW,
  parameter logic [HOST_AW-1:0] RESET_BASE = 16'h0300
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] io_addr,
  input  logic               io_rd,
  input  logic               io_wr,
  input  logic [DW-1:0]      io_wdata,
  output logic [DW-1:0]      io_rdata,
  output logic               io_hit,
  input  logic               rx_new,
  input  logic               tx_room,
  output logic               irq
);

  localparam int               WAW      = SAW - 1;
  localparam logic [SAW-1:0]   PTR_STEP = SAW'(2);
  localparam logic [HOST_AW-1:0] BASE_MASK = ~HOST_AW'(15);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // State
  logic [HOST_AW-1:0] base_q, base_d;
  logic [SAW-1:0]     ptr_q, ptr_d;
  logic [DW-1:0]      cfg_q, cfg_d;
  logic               evt_q, evt_d;
  logic               room_q;
  logic [DW-1:0]      rdata_q, rdata_d;

  // Decode
  logic  hit;
  port_e port;

  iopb_decode #(.HOST_AW(HOST_AW)) u_decode (
    .addr (io_addr),
    .base (base_q),
    .hit  (hit),
    .port (port)
  );

  logic acc_rd, acc_wr, is_rxtx, is_pdata, pd_wr;
  assign acc_rd   = io_rd && hit;
  assign acc_wr   = io_wr && hit;
  assign is_rxtx  = (port == P_DATA0) || (port == P_DATA1);
  assign is_pdata = (port == P_PDATA0) || (port == P_PDATA1);
  assign pd_wr    = acc_wr && is_pdata;

  // Frame streaming indexes
  logic [SAW-1:0] rx_idx, tx_idx;
  logic           rx_more;
  logic [DW-1:0]  ram_rdata;

  iopb_stream #(.SAW(SAW), .DW(DW)) u_stream (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rx_restart (rx_new),
    .rx_adv     (acc_rd && is_rxtx && rx_more),
    .cap_word   (ram_rdata),
    .tx_restart (acc_wr && (port == P_TXCMD)),
    .tx_adv     (acc_wr && is_rxtx),
    .rx_idx     (rx_idx),
    .tx_idx     (tx_idx),
    .rx_more    (rx_more)
  );

  // Internal space
  logic           ram_we;
  logic [SAW-1:0] wr_byte, rd_byte;

  always_comb begin
    ram_we  = 1'b0;
    wr_byte = ptr_q;
    if (acc_wr) begin
      unique case (port)
        P_DATA0, P_DATA1: begin
          ram_we  = 1'b1;
          wr_byte = OFF_TXDATA + tx_idx;
        end
        P_TXCMD: begin
          ram_we  = 1'b1;
          wr_byte = OFF_TXCMD;
        end
        P_TXLEN: begin
          ram_we  = 1'b1;
          wr_byte = OFF_TXLEN;
        end
        P_PDATA0, P_PDATA1: begin
          ram_we  = 1'b1;
          wr_byte = ptr_q;
        end
        default: ram_we = 1'b0;
      endcase
    end
  end

  always_comb begin
    unique case (port)
      P_ISQ:              rd_byte = OFF_ISQ;
      P_PDATA0, P_PDATA1: rd_byte = ptr_q;
      default:            rd_byte = OFF_RXST + rx_idx;
    endcase
  end

  iopb_ram #(.WAW(WAW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (WAW'(wr_byte >> 1)),
    .wdata (io_wdata),
    .raddr (WAW'(rd_byte >> 1)),
    .rdata (ram_rdata)
  );

  // Next state: sideband registers and pointer
  logic room_rise, evt_clr;
  assign room_rise = tx_room && !room_q;
  assign evt_clr   = pd_wr && (ptr_q == OFF_BASE + OFF_EVT - OFF_BASE) && io_wdata[EVT_BIT];

  always_comb begin
    base_d = base_q;
    cfg_d  = cfg_q;
    if (pd_wr && (ptr_q == OFF_BASE)) begin
      base_d = HOST_AW'(io_wdata) & BASE_MASK;
    end
    if (pd_wr && (ptr_q == OFF_CFG)) begin
      cfg_d = io_wdata;
    end
    evt_d = room_rise || (evt_q && !evt_clr);
  end

  always_comb begin
    ptr_d = ptr_q;
    if (acc_wr && (port == P_PTR)) begin
      ptr_d = SAW'(io_wdata) & ~SAW'(1);
    end else if ((acc_rd || acc_wr) && is_pdata) begin
      ptr_d = ptr_q + PTR_STEP;
    end
  end

  // Read path
  logic [DW-1:0] page_val, rd_sel;

  always_comb begin
    if (ptr_q == OFF_BASE) begin
      page_val = DW'(base_q);
    end else if (ptr_q == OFF_CFG) begin
      page_val = cfg_q;
    end else if (ptr_q == OFF_EVT) begin
      page_val = DW'(evt_q) << EVT_BIT;
    end else begin
      page_val = ram_rdata;
    end
  end

  always_comb begin
    unique case (port)
      P_DATA0, P_DATA1:   rd_sel = rx_more ? ram_rdata : '0;
      P_TXCMD, P_TXLEN:   rd_sel = '0;
      P_ISQ:              rd_sel = ram_rdata;
      P_PTR:              rd_sel = DW'(ptr_q);
      P_PDATA0, P_PDATA1: rd_sel = page_val;
      default:            rd_sel = '0;
    endcase
    rdata_d = rdata_q;
    if (io_rd) begin
      rdata_d = hit ? rd_sel : '0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      base_q  <= RESET_BASE;
      ptr_q   <= '0;
      cfg_q   <= '0;
      evt_q   <= 1'b0;
      room_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      base_q  <= base_d;
      ptr_q   <= ptr_d;
      cfg_q   <= cfg_d;
      evt_q   <= evt_d;
      room_q  <= tx_room;
      rdata_q <= rdata_d;
    end
  end

  assign io_rdata = rdata_q;
  assign io_hit   = hit;
  assign irq      = evt_q && cfg_q[EVT_BIT];

  // Assertions
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (io_rd && !io_hit) |=> (io_rdata == '0)); // R1
  AST_BASE_STABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !io_wr |=> $stable(base_q)); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((io_rd || io_wr) && io_hit && is_pdata) |=> (ptr_q == $past(ptr_q) + PTR_STEP)); // R4
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (io_rd && io_hit && ((port == P_TXCMD) || (port == P_TXLEN))) |=> (io_rdata == '0)); // R5
  AST_IRQ_ON_ROOM: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(tx_room) && cfg_q[EVT_BIT] && !io_wr) |=> irq); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !io_rd |=> $stable(io_rdata)); // R10

endmodule

// File: tb/indirect_io_bridge_bench.sv
module indirect_io_bridge_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_rd, io_wr;
  logic [15:0] io_wdata;
  logic [15:0] io_rdata;
  logic        io_hit;
  logic        rx_new, tx_room;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  indirect_io_bridge u_indirect_io_bridge (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .io_hit   (io_hit),
    .rx_new   (rx_new),
    .tx_room  (tx_room),
    .irq      (irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    io_addr  = a;
    io_wdata = d;
    io_wr    = 1'b1;
    @(negedge clk);
    io_wr    = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    io_addr = a;
    io_rd   = 1'b1;
    @(negedge clk);
    io_rd   = 1'b0;
    d       = io_rdata;
  endtask

  task automatic probe(input string req, input logic [15:0] a, input logic exp);
    @(negedge clk);
    io_addr = a;
    #1;
    chk(req, {15'd0, io_hit}, {15'd0, exp});
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 40503) ^ 16'h5A5A;
  endfunction

  initial begin
    #(10 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] cb;
    logic [15:0] bases [4];
    io_addr = '0; io_rd = 0; io_wr = 0; io_wdata = '0;
    rx_new = 0; tx_room = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 / R10 reset state
    chk("R10 reset rdata", io_rdata, 16'h0000);
    chk("R9 reset irq", {15'd0, irq}, 16'h0000);
    for (int a = 16'h2F0; a < 16'h320; a++) begin
      probe("R1 window claim", 16'(a), (a >= 16'h300) && (a < 16'h310) && ((a % 2) == 0));
    end

    // R3 pointer
    rd(16'h030A, v); chk("R3 reset pointer", v, 16'h0000);
    wr(16'h030A, 16'h0457); rd(16'h030A, v); chk("R3 pointer bit0 cleared", v, 16'h0456);
    wr(16'h030A, 16'hF123); rd(16'h030A, v); chk("R3 pointer 12 bits", v, 16'h0122);

    // R10 hold, R1 miss read
    repeat (3) @(negedge clk);
    chk("R10 rdata held", io_rdata, 16'h0122);
    rd(16'h0350, v); chk("R1 unclaimed read", v, 16'h0000);

    // R4 sweep with alternating page ports
    wr(16'h030A, 16'h0600);
    for (int i = 0; i < 64; i++) wr((i % 2 == 0) ? 16'h030C : 16'h030E, pat(i));
    rd(16'h030A, v); chk("R4 pointer advance on writes", v, 16'h0680);
    wr(16'h030A, 16'h0600);
    for (int i = 0; i < 64; i++) begin
      rd((i % 2 == 0) ? 16'h030C : 16'h030E, v);
      chk("R4 page readback", v, pat(i));
    end
    rd(16'h030A, v); chk("R4 pointer advance on reads", v, 16'h0680);
    wr(16'h030A, 16'h0700); wr(16'h030C, 16'h1111); wr(16'h030E, 16'h2222);
    wr(16'h030A, 16'h0700); rd(16'h030C, v); chk("R4 32-bit lower word", v, 16'h1111);
    wr(16'h030A, 16'h0702); rd(16'h030C, v); chk("R4 32-bit upper word", v, 16'h2222);

    // R6 status queue
    wr(16'h030A, 16'h0120); wr(16'h030C, 16'hBEEF);
    rd(16'h0308, v); chk("R6 queue read", v, 16'hBEEF);
    wr(16'h0308, 16'h1234);
    rd(16'h0308, v); chk("R6 queue write ignored", v, 16'hBEEF);

    // R5 write-only ports
    wr(16'h0304, 16'h00C0); wr(16'h0306, 16'h0040);
    rd(16'h0304, v); chk("R5 command reads zero", v, 16'h0000);
    rd(16'h0306, v); chk("R5 length reads zero", v, 16'h0000);
    wr(16'h030A, 16'h0144);
    rd(16'h030C, v); chk("R5 command stored", v, 16'h00C0);
    rd(16'h030C, v); chk("R5 length stored", v, 16'h0040);

    // R7 transmit data
    wr(16'h0304, 16'h00C0);
    for (int i = 0; i < 10; i++) wr((i % 2 == 0) ? 16'h0300 : 16'h0302, pat(100 + i));
    wr(16'h0304, 16'h00C0);
    wr(16'h0300, 16'hAAAA);
    wr(16'h030A, 16'h0A00);
    for (int i = 0; i < 10; i++) begin
      rd(16'h030C, v);
      chk("R7 transmit buffer word", v, (i == 0) ? 16'hAAAA : pat(100 + i));
    end

    // R8 receive readout, lengths 0..7
    for (int len = 0; len < 8; len++) begin
      wr(16'h030A, 16'h0400);
      wr(16'h030C, 16'h5000 + 16'(len));
      wr(16'h030C, 16'(len));
      for (int w = 0; w < 4; w++) wr(16'h030C, pat(200 + len * 8 + w));
      @(negedge clk); rx_new = 1'b1;
      @(negedge clk); rx_new = 1'b0;
      for (int k = 0; k < 2 + (len + 1) / 2 + 2; k++) begin
        rd((k % 2 == 0) ? 16'h0300 : 16'h0302, v);
        if (k == 0)                       chk("R8 status first", v, 16'h5000 + 16'(len));
        else if (k == 1)                  chk("R8 length second", v, 16'(len));
        else if (k < 2 + (len + 1) / 2)   chk("R8 frame data", v, pat(200 + len * 8 + k - 2));
        else                              chk("R8 exhausted reads zero", v, 16'h0000);
      end
    end

    // R9 interrupt
    wr(16'h030A, 16'h0102); wr(16'h030C, 16'h0100);
    chk("R9 no irq before room", {15'd0, irq}, 16'h0000);
    @(negedge clk); tx_room = 1'b1;
    @(negedge clk);
    chk("R9 irq after room rise", {15'd0, irq}, 16'h0001);
    wr(16'h030A, 16'h012C); wr(16'h030C, 16'h0100);
    chk("R9 irq cleared", {15'd0, irq}, 16'h0000);
    wr(16'h030A, 16'h012C); rd(16'h030C, v); chk("R9 event cleared", v, 16'h0000);
    @(negedge clk); tx_room = 1'b0;
    @(negedge clk); tx_room = 1'b1;
    @(negedge clk);
    wr(16'h030A, 16'h0102); wr(16'h030C, 16'h0000);
    chk("R9 irq masked", {15'd0, irq}, 16'h0000);
    wr(16'h030A, 16'h012C); rd(16'h030C, v); chk("R9 event flag set", v, 16'h0100);

    // R2 relocation sweep
    bases[0] = 16'h1230; bases[1] = 16'hFFF0; bases[2] = 16'h0040; bases[3] = 16'h0300;
    cb = 16'h0300;
    for (int b = 0; b < 4; b++) begin
      wr(cb + 16'h000A, 16'h0020);
      wr(cb + 16'h000C, bases[b] | 16'h0007);
      for (int o = 0; o < 16; o += 2) probe("R2 new window claims", bases[b] + 16'(o), 1'b1);
      if (cb != bases[b]) probe("R2 old window released", cb, 1'b0);
      rd(bases[b] + 16'h000A, v); chk("R2 pointer after base write", v, 16'h0022);
      wr(bases[b] + 16'h000A, 16'h0020);
      rd(bases[b] + 16'h000C, v); chk("R2 base readback", v, bases[b]);
      cb = bases[b];
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule